// File: doc/BRIEF.md
# Expansion Security Interrupt Collector

This block gathers the status lines from on-chip and expansion memory protection controllers and from expansion bus-master security controllers, and makes them visible as read-only status words on a 32-bit register bus. Each line is passed through a two-flop synchroniser before it reaches its status word. On-chip memory protection controllers occupy the low half of their status word. Expansion sources occupy the upper half, starting at bit 16.

Software sets an enable mask for the master-controller events. The block drives one interrupt line, which is high while any enabled master-controller status bit is set. A write to a clear register sends a one-cycle clear pulse to each selected master controller. A separate register selects which master controllers run non-secure. The block also holds a 1-bit secure-response configuration and a 2-bit non-secure-callable configuration, and drives each onto its own output pins. A bridge-interrupt enable register is present but keeps only its upper half. The bridge status word always reads as zero.

The bus is word addressed and has a single cycle. A write takes effect at the clock edge where `bus_en` and `bus_we` are both high. Read data is combinational from the stored state while `bus_en` is high and `bus_we` is low. Word indices: 0 secure-response configuration, 1 non-secure-callable configuration, 2 protection-controller status, 3 master-controller status, 4 master-controller clear, 5 master-controller enable, 6 master-controller non-secure select, 7 bridge status, 8 bridge enable.

Top module: `secint_collector`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every readable register reads 0, and msc_irq_o, msc_clr_o, msc_ns_o, resp_err_o and callable_cfg_o are all 0.
- R2: The protection-controller status word (index 2) has bit n equal to mpc_int_i[n] and bit 16+n equal to mpc_exp_i[n]. All other bits are 0. A change on an input line is visible two clock edges later.
- R3: The master-controller status word (index 3) has bit 16+n equal to msc_exp_i[n]. All other bits are 0. The latency is the same two edges as in R2.
- R4: msc_irq_o is high exactly when some bit is set in both the master-controller status word and the enable register (index 5, stored in full and read back). It follows a write to the enable register in the cycle after that write's edge, and follows a status change together with the status word.
- R5: The non-secure select register (index 6) stores all 32 bits and reads them back. msc_ns_o[n] equals its bit 16+n from the edge of the write onward.
- R6: A write to index 4 drives msc_clr_o[n] to written bit 16+n for exactly one cycle after the write edge, after which the outputs return to 0. Reading index 4 returns 0.
- R7: Index 1 keeps written bits 1:0 and drives callable_cfg_o. Index 0 keeps written bit 0 and drives resp_err_o. Both read back only the kept bits.
- R8: The bridge enable register (index 8) keeps written bits 31:16, and bits 15:0 read as 0. The bridge status word (index 7) reads 0 even after it has been written.
- R9: Writes to the status words (indices 2 and 3) change neither their readback nor any output. Reads of unmapped indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| mpc_int_i | input | NUM_MPC | On-chip protection-controller status lines |
| mpc_exp_i | input | NUM_MPC_EXP | Expansion protection-controller status lines |
| msc_exp_i | input | NUM_MSC | Expansion master-controller status lines |
| msc_irq_o | output | 1 | Combined master-controller interrupt |
| msc_clr_o | output | NUM_MSC | One-cycle clear pulses to the master controllers |
| msc_ns_o | output | NUM_MSC | Non-secure select for each master controller |
| resp_err_o | output | 1 | Secure-response configuration |
| callable_cfg_o | output | 2 | Non-secure-callable configuration |

## Verification
Timing of each result:
- Status inputs pass through two flops. The bench samples one falling edge after a change and expects the old word, then samples at the second falling edge and expects the new word.
- Configuration, non-secure select and enable writes land at the write edge. Their outputs and msc_irq_o are sampled at the falling edge that follows that edge.
- A clear pulse is sampled at that same falling edge, and again one cycle later to confirm it has returned to 0.
- Reads are combinational. They are sampled 1 ns after the address is driven.

// File: rtl/secint_pkg.sv
// Shared constants for the expansion security interrupt collector.
// Assumes a 32-bit word and expansion sources packed from bit 16 upward.
package secint_pkg;
    localparam int WORD_W  = 32;
    localparam int HI_BASE = 16;

    // Word indices of the register map
    localparam int IDX_RESP  = 0;
    localparam int IDX_CALL  = 1;
    localparam int IDX_MPCST = 2;
    localparam int IDX_MSCST = 3;
    localparam int IDX_CLR   = 4;
    localparam int IDX_EN    = 5;
    localparam int IDX_NS    = 6;
    localparam int IDX_BRST  = 7;
    localparam int IDX_BREN  = 8;

    localparam int CALL_W  = 2;
    localparam int BREN_W  = WORD_W - HI_BASE;
endpackage

// File: rtl/secint_sync.sv
// Two-stage synchroniser for a vector of asynchronous level lines.
// Assumes each line is a slow level, so no bus coherency is needed.
module secint_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Capture the raw lines and then re-register them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/secint_regs.sv
// Register file: write decode, stored configuration and read mux.
// Assumes full-word writes and a word index on the address lines.
module secint_regs
    import secint_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [IW-1:0]     word_idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] mpc_stat,
    input  logic [WORD_W-1:0] msc_stat,
    output logic [WORD_W-1:0] rdata,
    output logic              resp_q,
    output logic [CALL_W-1:0] call_q,
    output logic [WORD_W-1:0] en_q,
    output logic [WORD_W-1:0] ns_q,
    output logic              clr_stb
);
    logic              wr;
    logic              rd;
    logic [BREN_W-1:0] bren_q;

    // Access qualifiers
    assign wr = bus_en &&  bus_we;
    assign rd = bus_en && !bus_we;

    // Strobe for the clear register: it holds no state of its own
    assign clr_stb = wr && (word_idx == IW'(IDX_CLR));

    // Stored registers, masked to their kept bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= 1'b0;
            call_q <= '0;
            en_q   <= '0;
            ns_q   <= '0;
            bren_q <= '0;
        end else if (wr) begin
            if (word_idx == IW'(IDX_RESP)) resp_q <= wdata[0];
            if (word_idx == IW'(IDX_CALL)) call_q <= wdata[CALL_W-1:0];
            if (word_idx == IW'(IDX_EN))   en_q   <= wdata;
            if (word_idx == IW'(IDX_NS))   ns_q   <= wdata;
            if (word_idx == IW'(IDX_BREN)) bren_q <= wdata[WORD_W-1:HI_BASE];
        end
    end

    // Read mux; write-only, bridge status and unmapped indices read 0
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (word_idx == IW'(IDX_RESP))  rdata = {{(WORD_W-1){1'b0}}, resp_q};
            if (word_idx == IW'(IDX_CALL))  rdata = {{(WORD_W-CALL_W){1'b0}}, call_q};
            if (word_idx == IW'(IDX_MPCST)) rdata = mpc_stat;
            if (word_idx == IW'(IDX_MSCST)) rdata = msc_stat;
            if (word_idx == IW'(IDX_EN))    rdata = en_q;
            if (word_idx == IW'(IDX_NS))    rdata = ns_q;
            if (word_idx == IW'(IDX_BREN))  rdata = {bren_q, {HI_BASE{1'b0}}};
        end
    end
endmodule

// File: rtl/secint_msc_ctrl.sv
// Master-controller side: combined interrupt, clear pulses, non-secure lines.
// Assumes status, enable and select slices are already aligned to bit 0.
module secint_msc_ctrl #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stat,
    input  logic [N-1:0] en,
    input  logic [N-1:0] ns_sel,
    input  logic         clr_stb,
    input  logic [N-1:0] clr_bits,
    output logic         irq_o,
    output logic [N-1:0] clr_o,
    output logic [N-1:0] ns_o
);
    logic [N-1:0] clr_q;

    // One-cycle clear pulses, held only for the cycle after the write
    always_ff @(posedge clk) begin
        if (!rst_n)       clr_q <= '0;
        else if (clr_stb) clr_q <= clr_bits;
        else              clr_q <= '0;
    end

    // Level interrupt, re-evaluated whenever status or enable moves
    assign irq_o = |(stat & en);
    assign clr_o = clr_q;
    assign ns_o  = ns_sel;
endmodule

// File: rtl/secint_collector.sv
// Top of the expansion security interrupt collector.
// Assumes NUM_MPC, NUM_MPC_EXP and NUM_MSC are each at most 16.
module secint_collector
    import secint_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int NUM_MPC     = 4,
    parameter int NUM_MPC_EXP = 4,
    parameter int NUM_MSC     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_en,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [WORD_W-1:0]      bus_wdata,
    output logic [WORD_W-1:0]      bus_rdata,
    input  logic [NUM_MPC-1:0]     mpc_int_i,
    input  logic [NUM_MPC_EXP-1:0] mpc_exp_i,
    input  logic [NUM_MSC-1:0]     msc_exp_i,
    output logic                   msc_irq_o,
    output logic [NUM_MSC-1:0]     msc_clr_o,
    output logic [NUM_MSC-1:0]     msc_ns_o,
    output logic                   resp_err_o,
    output logic [CALL_W-1:0]      callable_cfg_o
);
    localparam int MPC_W = NUM_MPC + NUM_MPC_EXP;

    logic [MPC_W-1:0]   mpc_sync;
    logic [NUM_MSC-1:0] msc_sync;
    logic [WORD_W-1:0]  mpc_stat_w;
    logic [WORD_W-1:0]  msc_stat_w;
    logic [WORD_W-1:0]  msc_en_q;
    logic [WORD_W-1:0]  msc_ns_q;
    logic               clr_stb;

    secint_sync #(.W(MPC_W)) u_mpc_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({mpc_exp_i, mpc_int_i}),
        .q_o   (mpc_sync)
    );

    secint_sync #(.W(NUM_MSC)) u_msc_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (msc_exp_i),
        .q_o   (msc_sync)
    );

    // Place on-chip sources low and expansion sources from bit 16
    always_comb begin
        mpc_stat_w = '0;
        msc_stat_w = '0;
        mpc_stat_w[0 +: NUM_MPC]           = mpc_sync[0 +: NUM_MPC];
        mpc_stat_w[HI_BASE +: NUM_MPC_EXP] = mpc_sync[NUM_MPC +: NUM_MPC_EXP];
        msc_stat_w[HI_BASE +: NUM_MSC]     = msc_sync;
    end

    secint_regs #(.IW(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .word_idx (bus_addr),
        .wdata    (bus_wdata),
        .mpc_stat (mpc_stat_w),
        .msc_stat (msc_stat_w),
        .rdata    (bus_rdata),
        .resp_q   (resp_err_o),
        .call_q   (callable_cfg_o),
        .en_q     (msc_en_q),
        .ns_q     (msc_ns_q),
        .clr_stb  (clr_stb)
    );

    secint_msc_ctrl #(.N(NUM_MSC)) u_msc (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat     (msc_sync),
        .en       (msc_en_q[HI_BASE +: NUM_MSC]),
        .ns_sel   (msc_ns_q[HI_BASE +: NUM_MSC]),
        .clr_stb  (clr_stb),
        .clr_bits (bus_wdata[HI_BASE +: NUM_MSC]),
        .irq_o    (msc_irq_o),
        .clr_o    (msc_clr_o),
        .ns_o     (msc_ns_o)
    );
endmodule

// File: rtl/secint_collector_chk.sv
// Assertion checker for secint_collector, attached by bind.
// Assumes it sees the top's ports plus the stored enable and status words.
module secint_collector_chk
    import secint_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int NUM_MSC = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_en,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [WORD_W-1:0]  bus_rdata,
    input logic               msc_irq_o,
    input logic [NUM_MSC-1:0] msc_clr_o,
    input logic [NUM_MSC-1:0] msc_ns_o,
    input logic               resp_err_o,
    input logic [CALL_W-1:0]  callable_cfg_o,
    input logic [WORD_W-1:0]  msc_en,
    input logic [WORD_W-1:0]  msc_stat
);
    logic wr_clr, wr_ns, wr_cfg, rd_bridge;

    // Decoded bus events seen from the ports
    assign wr_clr    = bus_en && bus_we && (bus_addr == ADDR_W'(IDX_CLR));
    assign wr_ns     = bus_en && bus_we && (bus_addr == ADDR_W'(IDX_NS));
    assign wr_cfg    = bus_en && bus_we && ((bus_addr == ADDR_W'(IDX_RESP)) ||
                                            (bus_addr == ADDR_W'(IDX_CALL)));
    assign rd_bridge = bus_en && !bus_we && ((bus_addr == ADDR_W'(IDX_BREN)) ||
                                             (bus_addr == ADDR_W'(IDX_BRST)));

    p_clr_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|msc_clr_o) |-> $past(wr_clr));

    p_clr_single_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|msc_clr_o) && !wr_clr) |=> (msc_clr_o == '0));

    p_ns_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ns |=> $stable(msc_ns_o));

    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cfg |=> $stable({resp_err_o, callable_cfg_o}));

    p_bridge_low_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bridge |-> (bus_rdata[HI_BASE-1:0] == '0));

    p_irq_needs_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        msc_irq_o |-> ((msc_en != '0) && (msc_stat != '0)));
endmodule

bind secint_collector secint_collector_chk #(
    .ADDR_W  (ADDR_W),
    .NUM_MSC (NUM_MSC)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_en         (bus_en),
    .bus_we         (bus_we),
    .bus_addr       (bus_addr),
    .bus_rdata      (bus_rdata),
    .msc_irq_o      (msc_irq_o),
    .msc_clr_o      (msc_clr_o),
    .msc_ns_o       (msc_ns_o),
    .resp_err_o     (resp_err_o),
    .callable_cfg_o (callable_cfg_o),
    .msc_en         (msc_en_q),
    .msc_stat       (msc_stat_w)
);

// File: tb/secint_collector_bench.sv
module secint_collector_bench;
    localparam int AW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  mpc_int_i = '0;
    logic [3:0]  mpc_exp_i = '0;
    logic [3:0]  msc_exp_i = '0;
    logic        msc_irq_o;
    logic [3:0]  msc_clr_o;
    logic [3:0]  msc_ns_o;
    logic        resp_err_o;
    logic [1:0]  callable_cfg_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    secint_collector u_secint_collector (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mpc_int_i(mpc_int_i), .mpc_exp_i(mpc_exp_i), .msc_exp_i(msc_exp_i),
        .msc_irq_o(msc_irq_o), .msc_clr_o(msc_clr_o), .msc_ns_o(msc_ns_o),
        .resp_err_o(resp_err_o), .callable_cfg_o(callable_cfg_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Write one word; returns at the falling edge after the write edge
    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = AW'(idx); bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    // Combinational read, sampled 1 ns after the address is driven
    task automatic rd(input int idx, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = AW'(idx);
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int i = 0; i < 16; i++) begin
            rd(i, d);
            check("R1 reset readback", d, 32'h0);
        end
        check("R1 reset outputs",
              {22'h0, msc_irq_o, msc_clr_o, msc_ns_o, resp_err_o, callable_cfg_o}, 32'h0);
    endtask

    task automatic t_mpc_status;
        logic [31:0] d;
        @(negedge clk);
        mpc_int_i = 4'b0101; mpc_exp_i = 4'b1000;
        @(negedge clk);
        rd(2, d); check("R2 status before second edge", d, 32'h0);
        @(negedge clk);
        rd(2, d); check("R2 status placement", d, 32'h0008_0005);
        mpc_int_i = 4'b1000; mpc_exp_i = 4'b0011;
        @(negedge clk); @(negedge clk);
        rd(2, d); check("R2 second pattern", d, 32'h0003_0008);
    endtask

    task automatic t_msc_status;
        logic [31:0] d;
        @(negedge clk);
        msc_exp_i = 4'b0110;
        @(negedge clk); @(negedge clk);
        rd(3, d); check("R3 status placement", d, 32'h0006_0000);
        check("R4 no irq with enable clear", {31'h0, msc_irq_o}, 32'h0);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        wr(5, 32'h0001_0000);
        check("R4 disjoint enable keeps irq low", {31'h0, msc_irq_o}, 32'h0);
        wr(5, 32'h0004_0000);
        check("R4 matching enable raises irq", {31'h0, msc_irq_o}, 32'h1);
        rd(5, d); check("R4 enable readback", d, 32'h0004_0000);
        msc_exp_i = 4'b0000;
        @(negedge clk);
        check("R4 irq held until status syncs", {31'h0, msc_irq_o}, 32'h1);
        @(negedge clk);
        check("R4 irq drops with status", {31'h0, msc_irq_o}, 32'h0);
    endtask

    task automatic t_ns;
        logic [31:0] d;
        wr(6, 32'hA5A5_0003);
        check("R5 ns outputs", {28'h0, msc_ns_o}, 32'h5);
        rd(6, d); check("R5 ns readback", d, 32'hA5A5_0003);
        wr(6, 32'h000A_0000);
        check("R5 ns second pattern", {28'h0, msc_ns_o}, 32'hA);
    endtask

    task automatic t_clear;
        logic [31:0] d;
        wr(4, 32'h0009_FFFF);
        check("R6 clear pulse", {28'h0, msc_clr_o}, 32'h9);
        @(negedge clk);
        check("R6 clear pulse ends", {28'h0, msc_clr_o}, 32'h0);
        rd(4, d); check("R6 clear reads zero", d, 32'h0);
    endtask

    task automatic t_cfg;
        logic [31:0] d;
        wr(1, 32'hFFFF_FFFF);
        check("R7 callable output", {30'h0, callable_cfg_o}, 32'h3);
        rd(1, d); check("R7 callable readback", d, 32'h3);
        wr(0, 32'hFFFF_FFFE);
        check("R7 resp bit0 only", {31'h0, resp_err_o}, 32'h0);
        wr(0, 32'h0000_0001);
        check("R7 resp output", {31'h0, resp_err_o}, 32'h1);
        rd(0, d); check("R7 resp readback", d, 32'h1);
    endtask

    task automatic t_bridge;
        logic [31:0] d;
        wr(8, 32'h1234_5678);
        rd(8, d); check("R8 bridge enable upper half", d, 32'h1234_0000);
        wr(7, 32'hFFFF_FFFF);
        rd(7, d); check("R8 bridge status zero", d, 32'h0);
    endtask

    task automatic t_readonly;
        logic [31:0] d;
        wr(2, 32'hFFFF_FFFF);
        wr(3, 32'hFFFF_FFFF);
        rd(2, d); check("R9 mpc status unchanged", d, 32'h0003_0008);
        rd(3, d); check("R9 msc status unchanged", d, 32'h0);
        check("R9 outputs unchanged",
              {26'h0, msc_irq_o, msc_clr_o, resp_err_o}, 32'h1);
        rd(15, d); check("R9 unmapped reads zero", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mpc_status();
        t_msc_status();
        t_irq();
        t_ns();
        t_clear();
        t_cfg();
        t_bridge();
        t_readonly();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule